// File: doc/BRIEF.md
# Two-Section Presettable Decade Counter

A 4-bit counter made of two sections with their own count clocks. The lower section is a divide-by-two flip-flop that drives `q[0]`. The upper section is a divide-by-five counter that drives `q[3:1]`. Neither section is tied to the other inside the block. The user wires them together outside it. Feeding `q[0]` into the upper count clock gives an 8-4-2-1 decade count. Feeding `q[3]` into the lower count clock, with the input clock applied to the upper section, gives a bi-quinary decade whose `q[0]` is a divide-by-ten square wave with 50% duty.

The whole block runs in one system-clock domain. Both count clocks are sampled on `clk`, and a section steps one system clock after its input is first sampled low following a high sample. An active-low clear and an active-low parallel load reach the outputs combinationally, as asynchronous controls would. The stored state takes the same priority on the next `clk` edge: clear first, then load, then counting. Holding the load low with no count clocks applied turns the block into a 4-bit transparent latch. The parameter `BINARY_UPPER` changes the upper section to divide-by-eight, which gives a modulo-16 counter when `q[0]` drives the upper count clock.

Top module: `two_section_counter`

## Requirements
- R1: While `clear_n` is 0, `q` reads 0000 in the same cycle whatever `load_n` and `din` are, and the stored state is zero afterwards.
- R2: While `clear_n` is 1 and `load_n` is 0, `q` equals `din` in the same cycle and follows changes of `din`. After `load_n` returns to 1, `q` holds the last loaded value.
- R3: `q[0]` toggles once for each high-to-low transition of `cnt_clk_a`. A low-to-high transition does not change `q`.
- R4: With `BINARY_UPPER`=0, each high-to-low transition of `cnt_clk_b` steps `q[3:1]` through 000, 001, 010, 011, 100 and then back to 000, and leaves `q[0]` unchanged.
- R5: An upper value loaded outside that range (101, 110, 111) goes to 001, 010 or 011 respectively on the next upper count. Any upper count therefore leaves a value of 100 or below.
- R6: With `q[0]` wired to `cnt_clk_b`, falling edges on `cnt_clk_a` make `q` count 0 to 9 in binary-coded decimal and then return to 0.
- R7: With `q[3]` wired to `cnt_clk_a` and starting from zero, `q[0]` stays low for 5 falling edges of `cnt_clk_b` and then high for 5, which is a 50% duty over each group of 10.
- R8: A count-clock transition seen while `clear_n` or `load_n` is 0 is dropped. No count is applied when the control returns high.
- R9: With `BINARY_UPPER`=1 and `q[0]` wired to `cnt_clk_b`, `q` counts 0 to 15 and wraps to 0.
- R10: A synchronous `rst` clears the stored state, so `q` reads 0000 after reset with `clear_n` and `load_n` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cnt_clk_a | input | 1 | Count clock of the divide-by-two section, acts on falling transitions |
| cnt_clk_b | input | 1 | Count clock of the upper section, acts on falling transitions |
| clear_n | input | 1 | Active-low clear, highest priority |
| load_n | input | 1 | Active-low parallel load / latch enable |
| din | input | 4 | Parallel data; bit 0 goes to the lower section, bits 3:1 to the upper |
| q | output | 4 | Counter value; `q[0]` lower section, `q[3:1]` upper section |

## Verification
The bench checks that clear wins over an active load in the same cycle. If the priority were swapped, `q` would show `din` instead of zero. It loads the three out-of-range upper values and confirms each is back in range after one count. A wrong next-state table would leave the counter stuck in or cycling through illegal codes. It sends count-clock falls while clear or load is held and checks that no extra count appears after release. A detector that kept the edge pending would move `q` one step. The BCD and bi-quinary wirings are run through whole cycles: an off-by-one wrap shows up as a count of 10 or as a 4/6 duty on `q[0]`.

// File: rtl/dc_pkg.sv
package dc_pkg;

    localparam int unsigned LO_W   = 1;
    localparam int unsigned UP_W   = 3;
    localparam int unsigned Q_W    = LO_W + UP_W;
    localparam int unsigned N_CLKS = 2;

    // stored counter state, packed so that it lines up with the q bus
    typedef struct packed {
        logic [UP_W-1:0] up;
        logic [LO_W-1:0] lo;
    } dc_state_t;

    // decoded control priority for the stored state
    typedef struct packed {
        logic clr;
        logic load;
    } dc_ctl_t;

    function automatic dc_ctl_t dc_decode(input logic clear_n, input logic load_n);
        dc_ctl_t c;
        c.clr  = ~clear_n;
        c.load = clear_n & ~load_n;
        return c;
    endfunction

    // next value of a modulo-m stage; codes at or above m fold back by m-1
    function automatic int unsigned dc_next(input int unsigned s, input int unsigned m);
        if (s + 1 == m)
            return 0;
        else if (s >= m)
            return s - (m - 1);
        else
            return s + 1;
    endfunction

endpackage

// File: rtl/dc_fall_detect.sv
module dc_fall_detect (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic fall
);
    logic s_cur;
    logic s_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_cur  <= 1'b0;
            s_prev <= 1'b0;
        end else begin
            s_cur  <= raw;
            s_prev <= s_cur;
        end
    end

    assign fall = s_prev & ~s_cur;
endmodule

// File: rtl/dc_stage.sv
module dc_stage #(
    parameter int unsigned W   = 3,
    parameter int unsigned MOD = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] q
);
    import dc_pkg::*;

    logic [W-1:0] q_next;

    always_comb begin
        q_next = W'(dc_next(32'(q), MOD));
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (step)
            q <= q_next;
    end
endmodule

// File: rtl/dc_out_mux.sv
module dc_out_mux
    import dc_pkg::*;
(
    input  logic           clear_n,
    input  logic           load_n,
    input  logic [Q_W-1:0] din,
    input  dc_state_t      st,
    output logic [Q_W-1:0] q
);
    always_comb begin
        if (!clear_n)
            q = '0;
        else if (!load_n)
            q = din;
        else
            q = st;
    end
endmodule

// File: rtl/two_section_counter.sv
module two_section_counter
    import dc_pkg::*;
#(
    parameter bit BINARY_UPPER = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cnt_clk_a,
    input  logic       cnt_clk_b,
    input  logic       clear_n,
    input  logic       load_n,
    input  logic [3:0] din,
    output logic [3:0] q
);
    localparam int unsigned LO_MOD = 2;
    localparam int unsigned UP_MOD = BINARY_UPPER ? 8 : 5;

    logic [N_CLKS-1:0] raw_clks;
    logic [N_CLKS-1:0] fall_v;
    logic [LO_W-1:0]   lo_q;
    logic [UP_W-1:0]   up_q;
    dc_ctl_t           ctl;
    dc_state_t         st;

    assign raw_clks = {cnt_clk_b, cnt_clk_a};
    assign ctl      = dc_decode(clear_n, load_n);

    for (genvar i = 0; i < N_CLKS; i++) begin : g_fd
        dc_fall_detect u_fd (
            .clk  (clk),
            .rst  (rst),
            .raw  (raw_clks[i]),
            .fall (fall_v[i])
        );
    end

    dc_stage #(.W(LO_W), .MOD(LO_MOD)) u_lo (
        .clk      (clk),
        .rst      (rst),
        .clr      (ctl.clr),
        .load     (ctl.load),
        .load_val (din[LO_W-1:0]),
        .step     (fall_v[0]),
        .q        (lo_q)
    );

    dc_stage #(.W(UP_W), .MOD(UP_MOD)) u_up (
        .clk      (clk),
        .rst      (rst),
        .clr      (ctl.clr),
        .load     (ctl.load),
        .load_val (din[Q_W-1:LO_W]),
        .step     (fall_v[1]),
        .q        (up_q)
    );

    always_comb begin
        st.up = up_q;
        st.lo = lo_q;
    end

    dc_out_mux u_mux (
        .clear_n (clear_n),
        .load_n  (load_n),
        .din     (din),
        .st      (st),
        .q       (q)
    );
endmodule

// File: rtl/dc_checker.sv
module dc_checker #(
    parameter bit BINARY_UPPER = 1'b0
) (
    input logic       clk,
    input logic       rst,
    input logic       clear_n,
    input logic       load_n,
    input logic [3:0] din,
    input logic       lo,
    input logic [2:0] up,
    input logic [1:0] fall
);
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        !clear_n |=> (lo == 1'b0 && up == 3'd0)); // R1

    AST_LOAD_CAPTURES: assert property (@(posedge clk) disable iff (rst)
        (clear_n && !load_n) |=> ({up, lo} == $past(din))); // R2

    AST_LO_TOGGLES: assert property (@(posedge clk) disable iff (rst)
        (clear_n && load_n && fall[0]) |=> (lo != $past(lo))); // R3

    AST_LO_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (clear_n && load_n && !fall[0]) |=> $stable(lo)); // R8

    AST_UP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (clear_n && load_n && !fall[1]) |=> $stable(up)); // R4

    AST_UP_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (!BINARY_UPPER && clear_n && load_n && fall[1]) |=> (up <= 3'd4)); // R5
endmodule

bind two_section_counter dc_checker #(.BINARY_UPPER(BINARY_UPPER)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .clear_n (clear_n),
    .load_n  (load_n),
    .din     (din),
    .lo      (lo_q),
    .up      (up_q),
    .fall    (fall_v)
);

// File: tb/sim_two_section_counter.sv
module sim_two_section_counter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       a_drv = 1'b1;
    logic       b_drv = 1'b1;
    logic       bin_drv = 1'b1;
    logic [1:0] mode = 2'd0;   // 0 separate, 1 BCD wiring, 2 bi-quinary wiring
    logic       clear_n = 1'b1;
    logic       load_n = 1'b1;
    logic [3:0] din = 4'd0;
    logic [3:0] q;
    logic [3:0] bq;
    logic       cp_a, cp_b;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    assign cp_a = (mode == 2'd2) ? q[3] : a_drv;
    assign cp_b = (mode == 2'd1) ? q[0] : b_drv;

    two_section_counter u0 (
        .clk(clk), .rst(rst), .cnt_clk_a(cp_a), .cnt_clk_b(cp_b),
        .clear_n(clear_n), .load_n(load_n), .din(din), .q(q)
    );

    two_section_counter #(.BINARY_UPPER(1'b1)) u_bin (
        .clk(clk), .rst(rst), .cnt_clk_a(bin_drv), .cnt_clk_b(bq[0]),
        .clear_n(clear_n), .load_n(load_n), .din(din), .q(bq)
    );

    function automatic int up_step(input int u);
        if (u == 4) return 0;
        if (u > 4) return u - 4;
        return u + 1;
    endfunction

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_clks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_a();
        a_drv = 1'b0; wait_clks(4);
        a_drv = 1'b1; wait_clks(4);
    endtask

    task automatic pulse_b();
        b_drv = 1'b0; wait_clks(4);
        b_drv = 1'b1; wait_clks(4);
    endtask

    task automatic load_val(input logic [3:0] v);
        din = v; load_n = 1'b0; wait_clks(3);
        load_n = 1'b1; wait_clks(2);
    endtask

    initial begin
        int lo_m, up_m, highs;
        logic [3:0] v;
        void'($urandom(32'd1234));
        wait_clks(3);
        rst = 1'b0;
        wait_clks(2);
        chk("R10 reset u0", q, 4'd0);
        chk("R10 reset u_bin", bq, 4'd0);

        // clear priority over load
        din = 4'b1011; load_n = 1'b0; clear_n = 1'b0; #1;
        chk("R1 clear over load", q, 4'd0);
        wait_clks(2);
        clear_n = 1'b1; #1;
        chk("R2 load visible", q, 4'b1011);
        din = 4'b0110; #1;
        chk("R2 latch follows din", q, 4'b0110);
        wait_clks(2);
        load_n = 1'b1; wait_clks(1);
        din = 4'b1111; #1;
        chk("R2 latch holds", q, 4'b0110);
        wait_clks(2);
        clear_n = 1'b0; #1;
        chk("R1 clear immediate", q, 4'd0);
        wait_clks(2);
        clear_n = 1'b1; wait_clks(2);
        chk("R1 state cleared", q, 4'd0);

        // lower section: falling toggles, rising does nothing
        a_drv = 1'b0; wait_clks(4);
        chk("R3 fall toggles", q, 4'b0001);
        a_drv = 1'b1; wait_clks(4);
        chk("R3 rise ignored", q, 4'b0001);
        pulse_a();
        chk("R3 second toggle", q, 4'b0000);

        // upper section sequence, q0 held at 1
        load_val(4'b0001);
        for (int k = 1; k <= 6; k++) begin
            pulse_b();
            chk("R4 div5 step", q, {3'(k % 5), 1'b1});
        end

        // illegal upper codes
        for (int u = 5; u < 8; u++) begin
            load_val({3'(u), 1'b0});
            pulse_b();
            chk("R5 illegal recovery", q, {3'(u - 4), 1'b0});
        end

        // edges under load or clear dropped
        din = 4'b0100; load_n = 1'b0;
        pulse_a(); pulse_b();
        load_n = 1'b1; wait_clks(4);
        chk("R8 edges under load", q, 4'b0100);
        clear_n = 1'b0;
        pulse_a(); pulse_b();
        clear_n = 1'b1; wait_clks(4);
        chk("R8 edges under clear", q, 4'b0000);

        // BCD wiring
        din = 4'd0; load_n = 1'b0; mode = 2'd1; wait_clks(6);
        load_n = 1'b1; wait_clks(6);
        for (int k = 1; k <= 12; k++) begin
            pulse_a();
            chk("R6 BCD count", q, 4'(k % 10));
        end

        // bi-quinary wiring
        din = 4'd0; load_n = 1'b0; mode = 2'd2; wait_clks(6);
        load_n = 1'b1; wait_clks(6);
        highs = 0;
        for (int k = 1; k <= 20; k++) begin
            pulse_b();
            chk("R7 biquinary state", q, {3'(k % 5), 1'(((k / 5) % 2))});
            if (q[0]) highs++;
        end
        chk("R7 duty over 20", 4'(highs), 4'd10);
        mode = 2'd0; load_n = 1'b0; wait_clks(6); load_n = 1'b1;

        // binary variant
        rst = 1'b1; wait_clks(3); rst = 1'b0; wait_clks(3);
        for (int k = 1; k <= 20; k++) begin
            bin_drv = 1'b0; wait_clks(4);
            bin_drv = 1'b1; wait_clks(4);
            chk("R9 modulo-16", bq, 4'(k % 16));
        end

        // random mix, separate sections
        lo_m = 0; up_m = 0;
        for (int n = 0; n < 300; n++) begin
            case ($urandom % 3)
                0: begin pulse_a(); lo_m ^= 1; chk("R3 random", q, {3'(up_m), 1'(lo_m)}); end
                1: begin pulse_b(); up_m = up_step(up_m); chk("R4 R5 random", q, {3'(up_m), 1'(lo_m)}); end
                default: begin
                    v = 4'($urandom);
                    load_val(v);
                    lo_m = int'(v[0]); up_m = int'(v[3:1]);
                    chk("R2 random load", q, v);
                end
            endcase
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule